// File: doc/BRIEF.md
# Function-Select GPIO Bank

A bank of up to sixteen general-purpose pins controlled over a simple register bus. Every pin carries a 4-bit mode selector. The selector either leaves the pad undriven as an input, drives it from a latched data bit, or hands the pad to one of several peripheral alternate functions. In alternate-function mode the peripheral supplies both the output value and the output enable. The pad levels pass through a two-flop synchronizer before they reach the bus or the peripherals.

The register layout depends on the pin count. With eight pins or fewer, one control word holds every selector. Wider banks split the selectors across two control words, and the data register moves up one word to make room. Software that sets the data bit before it switches a pin to output mode gets a pad that drives the correct level from the first active cycle.

Top module: `gpio_fsel_bank`

## Requirements
- R1: After reset every mode selector is 0, the data register is 0, the synchronizer holds 0, and pad_oe and pad_out are all 0.
- R2: The mode selector of pin n sits at bits [4*(n%8)+3 : 4*(n%8)] of a control word. Pins 0–7 use offset 0x0. When PINS > 8, pins 8–15 use offset 0x4. Control words read back as written, and bits for pins that do not exist read 0.
- R3: The data register is at offset 0x8 when PINS > 8 and at offset 0x4 otherwise, with bit n for pin n. A write sets the latched output bits. A read returns the latched bit for pins in mode 1 and the synchronized pad level for all other pins, with the upper bits 0.
- R4: Mode 0 (input) gives pad_oe = 0 and pad_out = 0 for that pin.
- R5: Mode 1 gives pad_oe = 1 and pad_out equal to the latched data bit, starting on the first cycle after the control write. A data value written earlier therefore appears on the pad with no intermediate level.
- R6: Mode 2+k, for k < ALT_N, drives pad_out[n] from af_dout[k*PINS+n] and pad_oe[n] from af_oe[k*PINS+n].
- R7: Mode codes of 2+ALT_N and above give pad_oe = 0, pad_out = 0 and af_din = 0 for that pin.
- R8: A pad input change becomes visible in read data and in af_din after the second rising clock edge that samples it, and not earlier.
- R9: af_din[n] carries the synchronized pad level while pin n is in an alternate-function mode and is 0 otherwise.
- R10: Reads of any unmapped offset return 0. Writes to unmapped offsets change no mode selector and no data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register access |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pad_in | input | PINS | Pad input levels |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables |
| af_dout | input | ALT_N*PINS | Peripheral output values, function k at bits k*PINS+n |
| af_oe | input | ALT_N*PINS | Peripheral output enables, same layout |
| af_din | output | PINS | Synchronized pad levels routed to peripherals |

## Verification
The bound checker tests on every cycle a set of timing-related properties. These are the pad state just after reset, the first-cycle drive when pin 0 enters output mode, the data-write-to-pad path, the input-mode release, the handling of unused mode codes, and that unmapped accesses have no effect and read as zero. The two-flop latency, the per-function source selection, and the readback mix of latched and sampled bits across all sixteen pins rest on the bench's reference model. The model replays every register write and pad change and compares all outputs each cycle, in both directed and random phases.

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank #(
  parameter int PINS   = 16,
  parameter int ALT_N  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [PINS-1:0]       pad_in,
  output logic [PINS-1:0]       pad_out,
  output logic [PINS-1:0]       pad_oe,
  input  logic [ALT_N*PINS-1:0] af_dout,
  input  logic [ALT_N*PINS-1:0] af_oe,
  output logic [PINS-1:0]       af_din
);
  localparam bit TWO_CTRL = (PINS > 8);
  localparam logic [ADDR_W-1:0] CTRL0    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL1    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DATA_OFF = TWO_CTRL ? ADDR_W'(8) : ADDR_W'(4);

  logic [PINS-1:0][3:0] mode_q;
  logic [PINS-1:0]      dout_q;
  logic [PINS-1:0]      sync1_q, sync2_q;
  logic [PINS-1:0]      rd_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dout_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (we && addr == DATA_OFF) dout_q <= wdata[PINS-1:0];
      for (int n = 0; n < PINS; n++)
        if (we && addr == ((n >= 8) ? CTRL1 : CTRL0))
          mode_q[n] <= wdata[(n%8)*4 +: 4];
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [3:0] m;
    logic is_out, is_alt, ao, ae;
    assign m      = mode_q[n];
    assign is_out = (m == 4'd1);
    assign is_alt = (m >= 4'd2) && (int'(m) < 2 + ALT_N);

    always_comb begin
      ao = 1'b0;
      ae = 1'b0;
      for (int a = 0; a < ALT_N; a++)
        if (m == 4'(2 + a)) begin
          ao = af_dout[a*PINS+n];
          ae = af_oe[a*PINS+n];
        end
    end

    assign pad_out[n] = is_out ? dout_q[n] : ao;
    assign pad_oe[n]  = is_out | ae;
    assign af_din[n]  = is_alt & sync2_q[n];
    assign rd_dat[n]  = is_out ? dout_q[n] : sync2_q[n];
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL0) begin
      for (int n = 0; n < PINS; n++)
        if (n < 8) rdata[(n%8)*4 +: 4] = mode_q[n];
    end else if (addr == DATA_OFF) begin
      rdata[PINS-1:0] = rd_dat;
    end else if (TWO_CTRL && addr == CTRL1) begin
      for (int n = 0; n < PINS; n++)
        if (n >= 8) rdata[(n%8)*4 +: 4] = mode_q[n];
    end
  end
endmodule

// File: rtl/gpio_fsel_bank_chk.sv
module gpio_fsel_bank_chk #(
  parameter int PINS   = 16,
  parameter int ALT_N  = 2,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  we,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic [PINS-1:0]       pad_out,
  input logic [PINS-1:0]       pad_oe,
  input logic [PINS-1:0]       af_din,
  input logic [PINS-1:0][3:0]  mode_q,
  input logic [PINS-1:0]       dout_q
);
  localparam bit TWO_CTRL = (PINS > 8);
  localparam logic [ADDR_W-1:0] DATA_OFF = TWO_CTRL ? ADDR_W'(8) : ADDR_W'(4);

  logic mapped;
  assign mapped = (addr == ADDR_W'(0)) || (addr == DATA_OFF) ||
                  (TWO_CTRL && addr == ADDR_W'(4));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

  // R5
  out_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(0) && wdata[3:0] == 4'h1) |=>
      (pad_oe[0] && pad_out[0] == $past(dout_q[0])));

  // R3
  data_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == DATA_OFF && mode_q[0] == 4'h1) |=> (pad_out[0] == $past(wdata[0])));

  // R4
  input_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(0) && wdata[3:0] == 4'h0) |=> (!pad_oe[0] && !pad_out[0] && !af_din[0]));

  // R7
  unused_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(mode_q[0]) >= 2 + ALT_N) |-> (!pad_oe[0] && !pad_out[0] && !af_din[0]));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !mapped) |=> ($stable(mode_q) && $stable(dout_q)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == 32'h0));
endmodule

bind gpio_fsel_bank gpio_fsel_bank_chk #(.PINS(PINS), .ALT_N(ALT_N), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .af_din(af_din), .mode_q(mode_q), .dout_q(dout_q)
);

// File: tb/gpio_fsel_bank_tb_top.sv
module gpio_fsel_bank_tb_top;
  localparam int P = 16;
  localparam int A = 2;

  logic clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [P-1:0] pad_in = 0, pad_out, pad_oe, af_din;
  logic [A*P-1:0] af_dout = 0, af_oe = 0;

  gpio_fsel_bank #(.PINS(P), .ALT_N(A), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .af_dout(af_dout), .af_oe(af_oe), .af_din(af_din));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  int mm[P];
  bit [P-1:0] md, s1, s2;

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 0;
      md = 0; s1 = 0; s2 = 0;
    end else begin
      s2 = s1;
      s1 = pad_in;
      if (we) begin
        if (addr == 0) for (int i = 0; i < 8; i++) mm[i] = int'(wdata[i*4 +: 4]);
        if (addr == 4) for (int i = 8; i < P; i++) mm[i] = int'(wdata[(i-8)*4 +: 4]);
        if (addr == 8) md = wdata[P-1:0];
      end
    end
    #2;
    if (!done) begin
      logic [P-1:0] eo, ee, ed, rdd;
      logic [31:0] er;
      for (int i = 0; i < P; i++) begin
        eo[i] = 0; ee[i] = 0; ed[i] = 0; rdd[i] = s2[i];
        if (mm[i] == 1) begin eo[i] = md[i]; ee[i] = 1; rdd[i] = md[i]; end
        else if (mm[i] >= 2 && mm[i] < 2 + A) begin
          eo[i] = af_dout[(mm[i]-2)*P + i];
          ee[i] = af_oe[(mm[i]-2)*P + i];
          ed[i] = s2[i];
        end
      end
      er = 0;
      if (addr == 0) for (int i = 0; i < 8; i++) er[i*4 +: 4] = 4'(mm[i]);
      else if (addr == 4) for (int i = 8; i < P; i++) er[(i-8)*4 +: 4] = 4'(mm[i]);
      else if (addr == 8) er[P-1:0] = rdd;
      cmp("pad_out", 32'(pad_out), 32'(eo));
      cmp("pad_oe", 32'(pad_oe), 32'(ee));
      cmp("af_din", 32'(af_din), 32'(ed));
      cmp("rdata", rdata, er);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [3:0] a, int n);
    @(negedge clk); addr = a; we = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    pad_in = 16'hBEEF;
    rd(8, 2);
    rst_n = 1;
    rd(0, 2); rd(4, 1); rd(8, 2);

    cur_req = "R2";
    wr(0, 32'h7654_3210);
    wr(4, 32'hFEDC_BA98);
    rd(0, 2); rd(4, 2);

    cur_req = "R5";
    wr(0, 32'h0);
    wr(4, 32'h0);
    wr(8, 32'h0000_A5C3);
    wr(0, 32'h1111_1111);
    wr(4, 32'h1111_1111);
    rd(8, 2);

    cur_req = "R3";
    wr(8, 32'hFFFF_3C5A);
    wr(0, 32'h0000_1111);
    pad_in = 16'h1234;
    rd(8, 4);

    cur_req = "R4";
    wr(0, 32'h0);
    wr(4, 32'h0);
    pad_in = 16'hF0F0;
    rd(8, 3);

    cur_req = "R8";
    pad_in = 16'h0F0F;
    rd(8, 1);
    pad_in = 16'hAAAA;
    rd(8, 1);
    pad_in = 16'h5555;
    rd(8, 3);

    cur_req = "R6";
    af_dout = 32'h1234_ABCD; af_oe = 32'hF00F_0FF0;
    wr(0, 32'h2323_2323);
    wr(4, 32'h3232_3232);
    rd(8, 2);
    af_dout = ~af_dout; af_oe = 32'h0FF0_F00F;
    rd(0, 2);

    cur_req = "R9";
    pad_in = 16'hC3A5;
    rd(8, 3);
    wr(0, 32'h0102_0304);
    rd(8, 3);

    cur_req = "R7";
    wr(0, 32'hFEDC_BA54);
    wr(4, 32'h4567_89AB);
    af_oe = '1; af_dout = '1; pad_in = '1;
    rd(4, 3);

    cur_req = "R10";
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h2, 32'h1111_1111);
    wr(4'h9, 32'h0);
    rd(4'hC, 1); rd(4'h1, 1); rd(4'hF, 1); rd(0, 1); rd(4, 1); rd(8, 1);

    cur_req = "R2";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      pad_in = 16'($urandom); af_dout = $urandom; af_oe = $urandom;
      we = $urandom_range(0, 2) == 0;
      addr = 4'($urandom_range(0, 3) * 4);
      if ($urandom_range(0, 7) == 0) addr = 4'($urandom);
      wdata = $urandom;
    end
    @(negedge clk); we = 0;
    cur_req = "R1";
    rst_n = 0;
    rd(0, 2);
    rst_n = 1;
    rd(8, 2);
    finish_run();
  end
endmodule